// File: doc/BRIEF.md
# Depth-Cascaded Memory Bank Wrapper

This block presents one deep, single-port memory with a one-cycle synchronous read. Inside it are several identical shallower banks. The upper address bits choose one bank, and the lower bits address a word inside that bank. Bank 0 holds the lowest addresses, and each following bank covers the next `BANK_DEPTH` words. Chip enable and write strobes reach only the bank the current address falls into.

Each bank answers a read one clock later. The output multiplexer therefore does not look at the live address. It uses a register that stores the bank number of the most recent qualified read. That register loads only when chip enable and read enable are both high, so cycles without a read leave the presented data alone.

When `TOTAL_DEPTH` does not exceed `BANK_DEPTH`, no selection logic is built and the one bank drives the output directly. `TOTAL_DEPTH` must be at least `BANK_DEPTH`. Two parameters cover wrappers that lack a chip-enable or read-enable pin. If a pin is absent, the read qualifier uses the remaining pin, or is always true when both are absent.

Top module: `depth_cascade_mem`

## Requirements
- R1: While `rst_n` is low, every bank's read register and the bank-select register clear to zero. After reset, `rdata` reads 0 until the first qualified read.
- R2: Address `a` is stored in bank `a / BANK_DEPTH` at word `a % BANK_DEPTH`. A read issued with `cen=1, ren=1` at clock edge N returns the word most recently written to `a` on `rdata` after edge N.
- R3: A write changes only the addressed word. The word at the same offset in every other bank keeps its value.
- R4: A word is written at an edge only when `cen=1` and `wen=1`. A cycle with `wen=1` and `cen=0` leaves the memory unchanged.
- R5: The bank-select register loads the address bank bits only when `cen=1` and `ren=1`, and holds its value otherwise.
- R6: In a cycle without a qualified read, `rdata` keeps its previous value, even if the address moves to another bank or a write takes place.
- R7: A read and a write to the same address in the same cycle return the old contents. The new value is seen by a later read.
- R8: Reads are correct at the first and last word of every bank, where the bank-select bits change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all banks and the select register |
| rst_n | input | 1 | Active-low synchronous reset of the read and select registers |
| addr | input | ADDR_W | Word address across the whole memory |
| wdata | input | DATA_W | Data to write |
| wen | input | 1 | Write enable, qualified by `cen` |
| cen | input | 1 | Chip enable |
| ren | input | 1 | Read enable, qualified by `cen` |
| rdata | output | DATA_W | Read data, valid one cycle after a qualified read |

## Verification
The memory is first filled through writes with `ren` low. Then reads go to random addresses spread over all banks, followed by a sweep of each bank's first and last word. A wrong slice of the select bits or a wrong bank order shows up as a mismatch in either pattern. Write-then-read pairs that also probe the same offset in a neighbouring bank show whether strobes leak across banks. Simultaneous read-write, writes with `cen` low, and runs of idle or write-only cycles aimed at other banks between reads separate a registered, read-qualified select from one that follows the live address.

// File: rtl/mem_cascade_pkg.sv
package mem_cascade_pkg;

    // Index width for a count of items, at least one bit.
    function automatic int idx_w(input int count);
        int w;
        w = 1;
        while ((1 << w) < count) begin
            w++;
        end
        return w;
    endfunction

    // Number of banks needed to cover a total depth.
    function automatic int bank_count(input int total, input int per_bank);
        return (total + per_bank - 1) / per_bank;
    endfunction

    // Width of the bank-select field, at least one bit.
    function automatic int sel_width(input int addr_w, input int off_w);
        return (addr_w > off_w) ? (addr_w - off_w) : 1;
    endfunction

endpackage

// File: rtl/cascade_bank.sv
module cascade_bank #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int AW    = mem_cascade_pkg::idx_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              wr_go;
    logic              rd_go;

    always_comb begin
        wr_go = en && we;
        rd_go = en && re;
        st_d  = st_q;
        if (rd_go) begin
            st_d.rdata = mem_q[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = st_q.rdata;

    // R6: a bank that is not read keeps its output word
    p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && re) |=> $stable(rdata));

endmodule

// File: rtl/cascade_decode.sv
module cascade_decode #(
    parameter int  NUM_BANKS = 4,
    parameter int  SEL_W     = 2,
    parameter bit  USE_CE    = 1'b1,
    parameter bit  USE_RE    = 1'b1
) (
    input  logic [SEL_W-1:0]     addr_hi,
    input  logic                 cen,
    input  logic                 ren,
    input  logic                 wen,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic                 rd_qual,
    output logic [SEL_W-1:0]     sel
);

    typedef struct packed {
        logic [NUM_BANKS-1:0] en;
        logic [NUM_BANKS-1:0] we;
        logic                 rdq;
        logic [SEL_W-1:0]     sel;
    } dec_t;

    dec_t dec_d;
    logic ce_term;
    logic re_term;

    always_comb begin
        ce_term     = USE_CE ? cen : 1'b1;
        re_term     = USE_RE ? ren : 1'b1;
        dec_d       = '0;
        dec_d.sel   = addr_hi;
        dec_d.rdq   = ce_term && re_term;
        for (int i = 0; i < NUM_BANKS; i++) begin
            dec_d.en[i] = ce_term && (addr_hi == SEL_W'(i));
            dec_d.we[i] = dec_d.en[i] && wen;
        end
    end

    assign bank_en = dec_d.en;
    assign bank_we = dec_d.we;
    assign rd_qual = dec_d.rdq;
    assign sel     = dec_d.sel;

    // R3: at most one bank is touched per cycle
    always_comb begin
        p_bank_en_onehot_r3: assert ($onehot0(bank_en));
    end

    // R4: no write strobe without the write request and chip enable
    always_comb begin
        p_we_needs_ce_r4: assert (!(|bank_we) || (wen && ce_term));
    end

endmodule

// File: rtl/cascade_read_steer.sv
module cascade_read_steer #(
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2,
    parameter int DATA_W    = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_qual,
    input  logic [SEL_W-1:0]                  sel,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rdata,
    output logic [DATA_W-1:0]                 rdata
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } steer_state_t;

    steer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_qual) begin
            st_d.sel = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (st_q.sel == SEL_W'(i)) begin
                rdata = bank_rdata[i];
            end
        end
    end

    // R5: the select register holds without a qualified read
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_qual |=> $stable(st_q.sel));

    // R5: the select register takes the bank bits of a qualified read
    p_sel_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_qual |=> (st_q.sel == $past(sel)));

endmodule

// File: rtl/depth_cascade_mem.sv
module depth_cascade_mem #(
    parameter int  TOTAL_DEPTH = 256,
    parameter int  BANK_DEPTH  = 64,
    parameter int  DATA_W      = 16,
    parameter bit  USE_CE      = 1'b1,
    parameter bit  USE_RE      = 1'b1,
    localparam int ADDR_W      = mem_cascade_pkg::idx_w(TOTAL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wen,
    input  logic              cen,
    input  logic              ren,
    output logic [DATA_W-1:0] rdata
);

    localparam int OFF_W     = mem_cascade_pkg::idx_w(BANK_DEPTH);
    localparam int NUM_BANKS = mem_cascade_pkg::bank_count(TOTAL_DEPTH, BANK_DEPTH);
    localparam int SEL_W     = mem_cascade_pkg::sel_width(ADDR_W, OFF_W);

    logic [SEL_W-1:0]                 addr_hi;
    logic [NUM_BANKS-1:0]             bank_en;
    logic [NUM_BANKS-1:0]             bank_we;
    logic                             rd_qual;
    logic [SEL_W-1:0]                 sel;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;

    generate
        if (ADDR_W > OFF_W) begin : g_hi_slice
            assign addr_hi = addr[ADDR_W-1:OFF_W];
        end else begin : g_hi_zero
            assign addr_hi = '0;
        end
    endgenerate

    cascade_decode #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .USE_CE    (USE_CE),
        .USE_RE    (USE_RE)
    ) u_decode (
        .addr_hi (addr_hi),
        .cen     (cen),
        .ren     (ren),
        .wen     (wen),
        .bank_en (bank_en),
        .bank_we (bank_we),
        .rd_qual (rd_qual),
        .sel     (sel)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            cascade_bank #(
                .DEPTH  (BANK_DEPTH),
                .DATA_W (DATA_W)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (bank_en[b]),
                .we    (bank_we[b]),
                .re    (rd_qual),
                .addr  (addr[OFF_W-1:0]),
                .wdata (wdata),
                .rdata (bank_rdata[b])
            );
        end

        if (NUM_BANKS > 1) begin : g_steer
            cascade_read_steer #(
                .NUM_BANKS (NUM_BANKS),
                .SEL_W     (SEL_W),
                .DATA_W    (DATA_W)
            ) u_steer (
                .clk        (clk),
                .rst_n      (rst_n),
                .rd_qual    (rd_qual),
                .sel        (sel),
                .bank_rdata (bank_rdata),
                .rdata      (rdata)
            );
        end else begin : g_direct
            assign rdata = bank_rdata[0];
        end
    endgenerate

    // R6: presented data does not move without a qualified read
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_qual |=> $stable(rdata));

    // R1: the output is zero in the cycle after a reset edge
    p_rdata_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));

endmodule

// File: tb/depth_cascade_mem_bench.sv
`timescale 1ns/1ps
module depth_cascade_mem_bench;

    localparam int TOTAL = 256;
    localparam int BANK  = 64;
    localparam int DW    = 16;
    localparam int AW    = 8;

    typedef struct {
        int          due;
        logic [DW-1:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wen = 1'b0;
    logic          cen = 1'b0;
    logic          ren = 1'b0;
    logic [DW-1:0] rdata;

    int            cycle = 0;
    int            checks = 0;
    int            errors = 0;
    item_t         sb_q[$];
    logic [DW-1:0] ref_mem [TOTAL];
    logic [DW-1:0] shown = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    depth_cascade_mem #(
        .TOTAL_DEPTH (TOTAL),
        .BANK_DEPTH  (BANK),
        .DATA_W      (DW)
    ) u_depth_cascade_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wen   (wen),
        .cen   (cen),
        .ren   (ren),
        .rdata (rdata)
    );

    // monitor: compares every due expectation away from the rising edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cycle) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: rdata=%h expected=%h (cycle %0d)", it.tag, rdata, it.exp, cycle);
            end
        end
    end

    // driver: one cycle of stimulus, called at a falling edge
    task automatic op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic c, input logic w, input logic r, input string tag);
        item_t it;
        addr  = a;
        wdata = d;
        cen   = c;
        wen   = w;
        ren   = r;
        if (c && r) begin
            shown = ref_mem[a];
        end
        it.due = cycle + 1;
        it.exp = shown;
        it.tag = tag;
        sb_q.push_back(it);
        if (c && w) begin
            ref_mem[a] = d;
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        for (int i = 0; i < TOTAL; i++) ref_mem[i] = '0;
        addr  = 8'h5a;
        cen   = 1'b1;
        ren   = 1'b1;
        repeat (3) @(negedge clk);
        cen   = 1'b0;
        ren   = 1'b0;
        rst_n = 1'b1;
        // R1: output cleared by reset before any read
        checks++;
        if (rdata !== '0) begin
            errors++;
            $display("FAIL R1: rdata=%h expected=%h", rdata, 16'h0);
        end

        // fill all words without reading (R6 holds zero meanwhile)
        for (int i = 0; i < TOTAL; i++) begin
            op(AW'(i), DW'(i * 37 + 16'h0a5), 1'b1, 1'b1, 1'b0, "R6");
        end

        // R2: random reads over all banks
        for (int k = 0; k < 40; k++) begin
            op(AW'($urandom_range(TOTAL - 1)), '0, 1'b1, 1'b0, 1'b1, "R2");
        end

        // R8: first and last word of every bank
        for (int b = 0; b < TOTAL / BANK; b++) begin
            op(AW'(b * BANK), '0, 1'b1, 1'b0, 1'b1, "R8");
            op(AW'(b * BANK + BANK - 1), '0, 1'b1, 1'b0, 1'b1, "R8");
        end

        // R2 / R3: write then read, then probe same offset in other banks
        for (int k = 0; k < 8; k++) begin
            a = AW'($urandom_range(TOTAL - 1));
            op(a, DW'($urandom), 1'b1, 1'b1, 1'b0, "R2");
            op(a, '0, 1'b1, 1'b0, 1'b1, "R2");
            op(a ^ AW'(BANK), '0, 1'b1, 1'b0, 1'b1, "R3");
            op(a ^ AW'(2 * BANK), '0, 1'b1, 1'b0, 1'b1, "R3");
        end

        // R4: write request without chip enable is dropped
        op(AW'(70), 16'hdead, 1'b0, 1'b1, 1'b0, "R4");
        op(AW'(70), '0, 1'b1, 1'b0, 1'b1, "R4");
        op(AW'(200), 16'hbeef, 1'b0, 1'b1, 1'b1, "R4");
        op(AW'(200), '0, 1'b1, 1'b0, 1'b1, "R4");

        // R7: read and write of one word in the same cycle
        op(AW'(130), 16'h1234, 1'b1, 1'b1, 1'b1, "R7");
        op(AW'(130), '0, 1'b1, 1'b0, 1'b1, "R7");

        // R5 / R6: non-read cycles aimed at other banks keep the shown word
        op(AW'(10), '0, 1'b1, 1'b0, 1'b1, "R5");
        op(AW'(75), 16'h7777, 1'b1, 1'b1, 1'b0, "R6");
        op(AW'(140), '0, 1'b0, 1'b0, 1'b1, "R5");
        op(AW'(250), '0, 1'b1, 1'b0, 1'b0, "R6");
        op(AW'(190), 16'h4242, 1'b0, 1'b1, 1'b0, "R6");
        op(AW'(75), '0, 1'b1, 1'b0, 1'b1, "R5");
        op(AW'(20), '0, 1'b0, 1'b0, 1'b0, "R6");
        op(AW'(20), '0, 1'b1, 1'b0, 1'b1, "R5");

        // drain remaining expectations
        cen = 1'b0;
        ren = 1'b0;
        wen = 1'b0;
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule